// File: doc/BRIEF.md
# Prescaled Event Timer

This block is an 8-bit up-counter meant to sit in the register file of a small processor core. Each count event comes either from the instruction-cycle enable or from an external input pin. The pin is synchronised, and either its rising or its falling transitions can be chosen. An optional power-of-two prescaler can divide the event stream before it reaches the counter. A 6-bit option word picks the source, the edge, the prescaler bypass and the division setting. The core loads this word with a dedicated write strobe.

The core reads the count at any time on a plain read bus. It writes the count like any file register. A write loads the new value, empties the prescaler and blocks counting for the next two instruction cycles, so that the written value stays readable for a moment. The counter wraps from 0xFF to 0x00 and raises no flag.

All pins are plain control and data pins. There is no valid/ready flow: the count is always available, and both write strobes take effect in the cycle they are seen, so they never stall.

Top module: `tmr_prescaled_timer`

## Requirements
- R1: After reset the count reads 0x00 and the option word is all ones. The timer then counts falling edges of the pin with no prescaler, and instruction cycles alone do not move it.
- R2: With option bit 5 at 0, each clock cycle with `cyc_en` high is one count event. Cycles with `cyc_en` low and all activity on `ext_pin` have no effect.
- R3: With option bit 5 at 1, events are transitions of `ext_pin` after a two-flop synchroniser, and `cyc_en` does not create events. Option bit 4 selects the edge: 0 counts rising edges, 1 counts falling edges.
- R4: Option bit 3 at 0 puts the prescaler in the path. Option bits 2:0 hold a setting PS, and the count then advances once every 2^(PS+1) events, so PS=7 divides by 256. Option bit 3 at 1 bypasses the prescaler, and every event advances the count.
- R5: A cycle with `tmr_we` high loads `tmr_wdata` into the count and clears the prescaler. The count of divided events starts afresh from that write.
- R6: After a timer write, the next two cycles with `cyc_en` high are dropped as events, and the prescaler does not advance in them. In internal-source mode, N enabled cycles after a write of V therefore give V plus the division of (N-2) events.
- R7: The count wraps from 0xFF to 0x00. Between timer writes it only ever holds its value or steps up by one.
- R8: A cycle with `opt_we` high loads `opt_wdata`, and the new settings govern events from the next cycle on. An option write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | High for one clock per instruction cycle |
| ext_pin | input | 1 | Asynchronous external count input |
| opt_we | input | 1 | Option word write strobe |
| opt_wdata | input | 6 | Option word: [5] source, [4] falling edge, [3] prescaler bypass, [2:0] PS |
| tmr_we | input | 1 | Timer register write strobe |
| tmr_wdata | input | 8 | Value written to the timer |
| tmr_rdata | output | 8 | Current count |

## Verification
The internal source is swept over all eight prescaler settings. Each setting is run once with `cyc_en` high every cycle and once with `cyc_en` high every other cycle, which tells a divider that counts clocks apart from one that counts instruction cycles, and catches an off-by-one in the ratio or in the two-cycle hold after a write. The external source is driven with a pulse train that ends on an extra rising edge, under both polarities and several division settings, so rising-edge and falling-edge counting give different results. Separate runs toggle only the pin that is not selected, single-step through the write hold, and load a value just below 0xFF to show wrap-around. They also check that an option write keeps the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W  = 3;
  localparam int OPT_W = PS_W + 3;

  typedef struct packed {
    logic            src_ext;    // 1: external pin, 0: instruction cycles
    logic            edge_fall;  // 1: falling edges of the pin count
    logic            pre_bypass; // 1: prescaler out of the path
    logic [PS_W-1:0] ps;         // divide by 2^(ps+1)
  } opt_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_ev
);
  logic s1_q, s2_q, prev_q;
  logic lvl_now, lvl_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_now = s2_q ^ fall_sel;
  assign lvl_old = prev_q ^ fall_sel;
  assign edge_ev = lvl_now & ~lvl_old;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> !edge_ev); // R3
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3,
  localparam int PRE_W = 2 ** PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            bypass,
  input  logic [PS_W-1:0] ps,
  input  logic            ev,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(ps));
  end

  assign tick = bypass ? ev : (ev & (&(pre_q | ~mask)));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || bypass) pre_q <= '0;
    else if (ev)                 pre_q <= pre_q + 1'b1;
  end

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0)); // R5
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !clr && !bypass) |=> $stable(pre_q)); // R4
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
  parameter int TMR_W    = 8,
  parameter int HOLD_CYC = 2,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             we,
  input  logic [TMR_W-1:0] wdata,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             hold
);
  logic [TMR_W-1:0] cnt_q;
  logic [HW-1:0]    hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (we) begin
      cnt_q  <= wdata;
      hold_q <= HW'(HOLD_CYC);
    end else begin
      if (cyc_en && hold_q != '0) hold_q <= hold_q - 1'b1;
      if (tick)                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign hold = (hold_q != '0);

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cnt_q == $past(wdata))); // R5
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !we) |=> $stable(cnt_q)); // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R7
endmodule

// File: rtl/tmr_prescaled_timer.sv
module tmr_prescaled_timer #(
  parameter int TMR_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_en,
  input  logic                      ext_pin,
  input  logic                      opt_we,
  input  logic [tmr_pkg::OPT_W-1:0] opt_wdata,
  input  logic                      tmr_we,
  input  logic [TMR_W-1:0]          tmr_wdata,
  output logic [TMR_W-1:0]          tmr_rdata
);
  import tmr_pkg::*;

  opt_t opt_q;
  logic ext_ev, src_ev, ev, tick, hold;

  always_ff @(posedge clk) begin
    if (!rst_n)      opt_q <= '1;
    else if (opt_we) opt_q <= opt_t'(opt_wdata);
  end

  tmr_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .fall_sel (opt_q.edge_fall),
    .edge_ev  (ext_ev)
  );

  assign src_ev = opt_q.src_ext ? ext_ev : cyc_en;
  assign ev     = src_ev & ~hold & ~tmr_we;

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_we),
    .bypass (opt_q.pre_bypass),
    .ps     (opt_q.ps),
    .ev     (ev),
    .tick   (tick)
  );

  tmr_count_reg #(.TMR_W(TMR_W), .HOLD_CYC(HOLD_CYC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cyc_en(cyc_en),
    .we    (tmr_we),
    .wdata (tmr_wdata),
    .tick  (tick),
    .cnt   (tmr_rdata),
    .hold  (hold)
  );

  AST_OPT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    opt_we |=> (opt_q == $past(opt_wdata))); // R8
  AST_IDLE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_q.src_ext && !cyc_en && !tmr_we) |=> $stable(tmr_rdata)); // R2
  AST_OPT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_we && !tmr_we && !tick) |=> $stable(tmr_rdata)); // R8
endmodule

// File: tb/tmr_prescaled_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_prescaled_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       opt_we = 1'b0;
  logic [5:0] opt_wdata = '0;
  logic       tmr_we = 1'b0;
  logic [7:0] tmr_wdata = '0;
  logic [7:0] tmr_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tmr_prescaled_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .opt_we(opt_we), .opt_wdata(opt_wdata), .tmr_we(tmr_we),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_opt(input logic [5:0] v);
    opt_wdata = v; opt_we = 1'b1;
    @(negedge clk);
    opt_we = 1'b0;
  endtask

  task automatic write_tmr(input logic [7:0] v);
    tmr_wdata = v; tmr_we = 1'b1; cyc_en = 1'b0;
    @(negedge clk);
    tmr_we = 1'b0;
  endtask

  // n enabled instruction cycles, optionally each followed by a disabled one
  task automatic run_en(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      cyc_en = 1'b1;
      @(negedge clk);
      if (gap) begin
        cyc_en = 1'b0;
        @(negedge clk);
      end
    end
    cyc_en = 1'b0;
  endtask

  task automatic set_pin(input logic v, input int hold);
    ext_pin = v;
    for (int i = 0; i < hold; i++) begin
      cyc_en = i[0];
      @(negedge clk);
    end
    cyc_en = 1'b0;
  endtask

  function automatic logic [7:0] divided(input int ev, input int ps, input bit byp);
    return byp ? 8'(ev) : 8'(ev >> (ps + 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 reset count", tmr_rdata, 8'h00);
    run_en(20, 1'b0);
    check("R1 default source ignores cycles", tmr_rdata, 8'h00);
    set_pin(1'b1, 6);
    check("R1 default ignores rising edge", tmr_rdata, 8'h00);
    set_pin(1'b0, 6);
    check("R1 default counts falling edge", tmr_rdata, 8'h01);

    // R4 R6 R2: internal source sweep over every division, two enable patterns
    for (int ps = 0; ps < 8; ps++) begin
      for (int g = 0; g < 2; g++) begin
        int n;
        n = 2 + 3 * (2 << ps) + 37;
        set_opt({3'b000, 3'(ps)});
        write_tmr(8'h20);
        run_en(n, g[0]);
        check($sformatf("R4 internal ps=%0d gap=%0d", ps, g), tmr_rdata,
              8'h20 + divided(n - 2, ps, 1'b0));
      end
    end

    // R6: single-step through the write hold, bypass
    set_opt(6'h08);
    write_tmr(8'h10);
    run_en(1, 1'b0);
    check("R6 hold cycle 1", tmr_rdata, 8'h10);
    run_en(1, 1'b0);
    check("R6 hold cycle 2", tmr_rdata, 8'h10);
    run_en(1, 1'b0);
    check("R6 first counted cycle", tmr_rdata, 8'h11);

    // R7: wrap
    write_tmr(8'hFC);
    run_en(8, 1'b0);
    check("R7 wrap FF to 00", tmr_rdata, 8'h02);

    // R2: pin and idle cycles ignored on internal source
    held = tmr_rdata;
    for (int k = 0; k < 10; k++) begin
      ext_pin = ~ext_pin;
      idle(4);
    end
    ext_pin = 1'b0;
    idle(4);
    check("R2 pin ignored on internal source", tmr_rdata, held);

    // R8: option write keeps count
    set_opt(6'h05);
    check("R8 option write keeps count", tmr_rdata, held);

    // R3 R4: external source, both polarities, several divisions
    for (int pol = 0; pol < 2; pol++) begin
      for (int mode = 0; mode < 3; mode++) begin
        bit byp;
        int ps, edges;
        byp = (mode == 0);
        ps  = (mode == 2) ? 1 : 0;
        set_opt({1'b1, 1'(pol), 1'(byp), 3'(ps)});
        write_tmr(8'h40);
        run_en(4, 1'b0);
        for (int k = 0; k < 13; k++) begin
          set_pin(1'b1, 5);
          set_pin(1'b0, 5);
        end
        set_pin(1'b1, 5);
        edges = (pol == 1) ? 13 : 14;
        check($sformatf("R3 external pol=%0d mode=%0d", pol, mode), tmr_rdata,
              8'h40 + divided(edges, ps, byp));
        set_pin(1'b0, 5);
      end
    end

    // R3: instruction cycles ignored on external source
    set_opt(6'h28);
    write_tmr(8'h77);
    run_en(30, 1'b0);
    check("R3 cycles ignored on external source", tmr_rdata, 8'h77);

    // R5: write clears a partly filled prescaler
    set_opt(6'h02);
    write_tmr(8'h00);
    run_en(2 + 5, 1'b0);
    write_tmr(8'h30);
    run_en(2 + 7, 1'b0);
    check("R5 prescaler restarted by write", tmr_rdata, 8'h30);
    run_en(1, 1'b0);
    check("R5 first tick after 8 fresh events", tmr_rdata, 8'h31);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule